// File: doc/BRIEF.md
# Vector-Length Loop Instruction Expander

This block sits between instruction decode and scalar issue. It holds a vector-length value (VL) written through its own write port. When a decoded instruction is accepted while VL is two or more, the block keeps that instruction as a template. It then sends VL ordinary scalar instructions to issue, one per accepted handshake. Every copy keeps the template's opcode and function field. The two source register numbers and the destination register number of copy k are the template's numbers plus k. While a multi-element expansion is running, the block raises a stall to fetch so that the program counter stays on the template instruction.

With VL at zero or one, the accepted instruction goes out once, unchanged, and fetch is never stalled. The issued instructions carry no vector marking, so downstream hazard tracking handles them like any other scalar instruction. Register numbers are 7 bits wide, for 128 architectural registers. An element whose offset register number would pass 127 is not issued. Instead, the block flags an error and ends the expansion rather than wrapping the number.

Top module: `vl_expander`

## Requirements
- R1: During and after reset, out_valid, fetch_stall, seq_done and seq_err are low and in_ready is high; the VL register resets to 0.
- R2: A write (vl_wr_en high at a rising edge) loads vl_wr_data into the VL register. A template accepted at that same edge uses the VL value held before the write. The new value applies from the next template on.
- R3: For an accepted template with VL of two or more, exactly VL instructions are issued. Element k (out_idx = k, counted from 0) carries the template's opcode unchanged and register numbers rs1+k, rs2+k and rd+k.
- R4: With VL equal to 0 or 1, the template is issued exactly once with unchanged fields and out_idx = 0, and fetch_stall stays low.
- R5: fetch_stall is high from the cycle after a template with VL of two or more is accepted through the cycle in which its final element is accepted (or its overflow is flagged). While fetch_stall is high, in_ready is high only in a cycle where an element is being accepted.
- R6: While out_valid is high and out_ready is low, the output instruction and out_idx stay unchanged, and out_valid stays high.
- R7: If any of rs1+k, rs2+k or rd+k exceeds 127 for element k, that element is not presented (out_valid low). seq_err is high for that one cycle, the expansion ends with no seq_done, fetch_stall drops, and the next cycle in_ready is high.
- R8: seq_done is a one-cycle pulse in the cycle after the final element of a template (including a single-element one) is accepted.
- R9: A VL write while an expansion is running does not change the number of elements issued for the current template.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vl_wr_en | input | 1 | VL register write strobe |
| vl_wr_data | input | VL_W | Value written to the VL register |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Block accepts the decoded instruction this cycle |
| in_op | input | 12 | Opcode and function field of the decoded instruction |
| in_rs1 | input | 7 | First source register number |
| in_rs2 | input | 7 | Second source register number |
| in_rd | input | 7 | Destination register number |
| out_valid | output | 1 | Scalar instruction presented to issue |
| out_ready | input | 1 | Issue stage accepts the presented instruction |
| out_op | output | 12 | Opcode and function field of the issued element |
| out_rs1 | output | 7 | Offset first source register number |
| out_rs2 | output | 7 | Offset second source register number |
| out_rd | output | 7 | Offset destination register number |
| out_idx | output | VL_W | Element index of the presented instruction |
| fetch_stall | output | 1 | Hold the program counter and stop fetch |
| seq_done | output | 1 | One-cycle pulse after the final element is accepted |
| seq_err | output | 1 | Register-number overflow; expansion ended |

## Verification
A wrong element index or a lost template shows at once, on the next accepted element, as a wrong register number or a wrong opcode. A length counter that reads the live VL instead of the captured one shows up when a sequence ends. It yields too many or too few elements, and a seq_done in the wrong cycle, after the last handshake. A bad overflow comparison either wraps a register number on the very element that should have stopped the sequence or ends a legal sequence early. In both cases the mismatch appears at the ports within one cycle of that element.

// File: rtl/vlx_pkg.sv
package vlx_pkg;

    localparam int REG_W    = 7;
    localparam int OP_W     = 12;
    localparam int NUM_OPND = 3;

    typedef logic [REG_W-1:0] regnum_t;
    typedef logic [OP_W-1:0]  opfield_t;

    typedef struct packed {
        opfield_t op;
        regnum_t  rs1;
        regnum_t  rs2;
        regnum_t  rd;
    } tmpl_t;

    localparam int OPND_RS1 = 2;
    localparam int OPND_RS2 = 1;
    localparam int OPND_RD  = 0;

    function automatic logic [NUM_OPND-1:0][REG_W-1:0] tmpl_operands(input tmpl_t t);
        logic [NUM_OPND-1:0][REG_W-1:0] v;
        v[OPND_RS1] = t.rs1;
        v[OPND_RS2] = t.rs2;
        v[OPND_RD]  = t.rd;
        return v;
    endfunction

endpackage

// File: rtl/vlx_vl_reg.sv
module vlx_vl_reg #(
    parameter int VL_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [VL_W-1:0] wr_data,
    output logic [VL_W-1:0] vl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vl <= '0;
        end else if (wr_en) begin
            vl <= wr_data;
        end
    end

endmodule

// File: rtl/vlx_operand_offset.sv
module vlx_operand_offset #(
    parameter int REG_W = 7,
    parameter int VL_W  = 8,
    parameter int N     = 3
) (
    input  logic [N-1:0][REG_W-1:0] base,
    input  logic [VL_W-1:0]         idx,
    output logic [N-1:0][REG_W-1:0] elem,
    output logic [N-1:0]            ovf
);

    localparam int SUM_W = ((REG_W > VL_W) ? REG_W : VL_W) + 1;
    localparam logic [SUM_W-1:0] REG_MAX = SUM_W'((1 << REG_W) - 1);

    for (genvar g = 0; g < N; g++) begin : g_opnd
        logic [SUM_W-1:0] sum;
        always_comb begin
            sum     = SUM_W'(base[g]) + SUM_W'(idx);
            elem[g] = sum[REG_W-1:0];
            ovf[g]  = (sum > REG_MAX);
        end
    end

endmodule

// File: rtl/vlx_seq_ctrl.sv
module vlx_seq_ctrl
    import vlx_pkg::*;
#(
    parameter int VL_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  tmpl_t           tpl_in,
    input  logic [VL_W-1:0] vl,
    input  logic            fire,
    input  logic            abort,
    output logic            active,
    output tmpl_t           tpl,
    output logic [VL_W-1:0] idx,
    output logic            last,
    output logic            multi,
    output logic            done
);

    logic [VL_W-1:0] len;
    logic [VL_W-1:0] eff_len;

    always_comb begin
        eff_len = (vl < VL_W'(2)) ? VL_W'(1) : vl;
        last    = (idx == len - VL_W'(1));
        multi   = (len > VL_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            tpl    <= '0;
            idx    <= '0;
            len    <= VL_W'(1);
            done   <= 1'b0;
        end else begin
            done <= fire && last;
            if (start) begin
                active <= 1'b1;
                tpl    <= tpl_in;
                idx    <= '0;
                len    <= eff_len;
            end else if (abort) begin
                active <= 1'b0;
            end else if (fire) begin
                if (last) begin
                    active <= 1'b0;
                end else begin
                    idx <= idx + VL_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/vl_expander.sv
module vl_expander
    import vlx_pkg::*;
#(
    parameter int VL_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vl_wr_en,
    input  logic [VL_W-1:0]      vl_wr_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [OP_W-1:0]      in_op,
    input  logic [REG_W-1:0]     in_rs1,
    input  logic [REG_W-1:0]     in_rs2,
    input  logic [REG_W-1:0]     in_rd,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [OP_W-1:0]      out_op,
    output logic [REG_W-1:0]     out_rs1,
    output logic [REG_W-1:0]     out_rs2,
    output logic [REG_W-1:0]     out_rd,
    output logic [VL_W-1:0]      out_idx,
    output logic                 fetch_stall,
    output logic                 seq_done,
    output logic                 seq_err
);

    logic                           active;
    logic                           last;
    logic                           multi;
    logic                           fire;
    logic                           accept;
    logic                           ovf_any;
    logic [VL_W-1:0]                vl_cur;
    logic [VL_W-1:0]                idx;
    tmpl_t                          tpl_in;
    tmpl_t                          tpl;
    logic [NUM_OPND-1:0][REG_W-1:0] elem;
    logic [NUM_OPND-1:0]            ovf;

    vlx_vl_reg #(.VL_W(VL_W)) u_vl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (vl_wr_en),
        .wr_data (vl_wr_data),
        .vl      (vl_cur)
    );

    always_comb begin
        tpl_in.op  = in_op;
        tpl_in.rs1 = in_rs1;
        tpl_in.rs2 = in_rs2;
        tpl_in.rd  = in_rd;
    end

    vlx_seq_ctrl #(.VL_W(VL_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .tpl_in (tpl_in),
        .vl     (vl_cur),
        .fire   (fire),
        .abort  (ovf_any),
        .active (active),
        .tpl    (tpl),
        .idx    (idx),
        .last   (last),
        .multi  (multi),
        .done   (seq_done)
    );

    vlx_operand_offset #(.REG_W(REG_W), .VL_W(VL_W), .N(NUM_OPND)) u_off (
        .base (tmpl_operands(tpl)),
        .idx  (idx),
        .elem (elem),
        .ovf  (ovf)
    );

    always_comb begin
        ovf_any     = active && (|ovf);
        out_valid   = active && !ovf_any;
        fire        = out_valid && out_ready;
        in_ready    = !active || (fire && last);
        accept      = in_valid && in_ready;
        fetch_stall = active && multi;
        seq_err     = ovf_any;
        out_op      = tpl.op;
        out_rs1     = elem[OPND_RS1];
        out_rs2     = elem[OPND_RS2];
        out_rd      = elem[OPND_RD];
        out_idx     = idx;
    end

endmodule

// File: rtl/vlx_checker.sv
module vlx_checker
    import vlx_pkg::*;
#(
    parameter int VL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OP_W-1:0]  out_op,
    input logic [REG_W-1:0] out_rs1,
    input logic [REG_W-1:0] out_rs2,
    input logic [REG_W-1:0] out_rd,
    input logic [VL_W-1:0]  out_idx,
    input logic             fetch_stall,
    input logic             seq_done,
    input logic             seq_err
);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !fetch_stall && !seq_done && !seq_err && in_ready));

    p_next_elem_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !in_ready) |=>
            (seq_err || (out_valid && $stable(out_op) &&
                         out_idx == VL_W'($past(out_idx) + VL_W'(1)))));

    p_stall_gate_r5: assert property (@(posedge clk) disable iff (rst)
        fetch_stall |-> (!in_ready || (out_valid && out_ready)));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_op) && $stable(out_rs1) && $stable(out_rs2) &&
             $stable(out_rd) && $stable(out_idx)));

    p_err_no_issue_r7: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> !out_valid);

    p_err_ends_r7: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> (!seq_err && !fetch_stall && in_ready));

    p_done_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> $past(out_valid && out_ready && in_ready));

endmodule

bind vl_expander vlx_checker #(.VL_W(VL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_op      (out_op),
    .out_rs1     (out_rs1),
    .out_rs2     (out_rs2),
    .out_rd      (out_rd),
    .out_idx     (out_idx),
    .fetch_stall (fetch_stall),
    .seq_done    (seq_done),
    .seq_err     (seq_err)
);

// File: tb/vl_expander_tb.sv
module vl_expander_tb;

    localparam int VL_W = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            vl_wr_en = 1'b0;
    logic [VL_W-1:0] vl_wr_data = '0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [11:0]     in_op = '0;
    logic [6:0]      in_rs1 = '0, in_rs2 = '0, in_rd = '0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [11:0]     out_op;
    logic [6:0]      out_rs1, out_rs2, out_rd;
    logic [VL_W-1:0] out_idx;
    logic            fetch_stall, seq_done, seq_err;

    always #4 clk = ~clk;

    vl_expander #(.VL_W(VL_W)) u_dut (
        .clk(clk), .rst(rst), .vl_wr_en(vl_wr_en), .vl_wr_data(vl_wr_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
        .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rd(in_rd),
        .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
        .out_rs1(out_rs1), .out_rs2(out_rs2), .out_rd(out_rd), .out_idx(out_idx),
        .fetch_stall(fetch_stall), .seq_done(seq_done), .seq_err(seq_err)
    );

    typedef struct {
        logic [11:0] op;
        int a, b, d, idx;
        string req;
    } item_t;

    item_t q[$];
    int checks = 0, fails = 0;
    int exp_done = 0, exp_err = 0, done_cnt = 0, err_cnt = 0;
    bit stall_seen = 0;
    int ready_mode = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Issue-side handshake driver
    always @(posedge clk) begin
        #1;
        cyc++;
        case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = ((cyc % 3) != 1);
            default: out_ready = 1'b0;
        endcase
    end

    // Monitor: pops expected elements and compares them
    bit          hold_prev = 0;
    logic [11:0] h_op;
    logic [6:0]  h_a, h_b, h_d;
    logic [VL_W-1:0] h_i;

    always @(negedge clk) begin
        if (!rst) begin
            if (fetch_stall) stall_seen = 1;
            if (seq_done) done_cnt++;
            if (seq_err) err_cnt++;
            if (fetch_stall && in_ready)
                check(out_valid && out_ready, "R5", "in_ready high while stalled w/o accept",
                      int'(in_ready), 0);
            if (hold_prev) begin
                check(out_valid && out_op == h_op && out_rs1 == h_a && out_rs2 == h_b &&
                      out_rd == h_d && out_idx == h_i, "R6", "held element changed idx",
                      int'(out_idx), int'(h_i));
            end
            hold_prev = out_valid && !out_ready;
            h_op = out_op; h_a = out_rs1; h_b = out_rs2; h_d = out_rd; h_i = out_idx;
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    check(0, "R3", "unexpected element idx", int'(out_idx), -1);
                end else begin
                    item_t e;
                    e = q.pop_front();
                    check(out_op == e.op, e.req, "op", int'(out_op), int'(e.op));
                    check(int'(out_rs1) == e.a, e.req, "rs1", int'(out_rs1), e.a);
                    check(int'(out_rs2) == e.b, e.req, "rs2", int'(out_rs2), e.b);
                    check(int'(out_rd) == e.d, e.req, "rd", int'(out_rd), e.d);
                    check(int'(out_idx) == e.idx, e.req, "idx", int'(out_idx), e.idx);
                end
            end
        end
    end

    // Driver: pushes expected elements, then offers the template
    task automatic send(input logic [11:0] op, input int a, input int b, input int d,
                        input int vl, input string req);
        int n;
        bit err;
        n = (vl <= 1) ? 1 : vl;
        err = 0;
        for (int k = 0; k < n; k++) begin
            if (a + k > 127 || b + k > 127 || d + k > 127) begin
                err = 1;
                break;
            end
            q.push_back('{op, a + k, b + k, d + k, k, req});
        end
        if (err) exp_err++; else exp_done++;
        @(posedge clk); #1;
        in_valid = 1'b1; in_op = op;
        in_rs1 = 7'(a); in_rs2 = 7'(b); in_rd = 7'(d);
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic write_vl(input int v);
        @(posedge clk); #1;
        vl_wr_en = 1'b1; vl_wr_data = VL_W'(v);
        @(posedge clk); #1;
        vl_wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int quiet;
        quiet = 0;
        for (int t = 0; t < 2000 && quiet < 4; t++) begin
            @(negedge clk);
            if (!out_valid && !fetch_stall && in_ready) quiet++; else quiet = 0;
        end
        check(q.size() == 0, req, "elements left unissued", q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && !fetch_stall && !seq_done && !seq_err && in_ready, "R1",
              "reset idle outputs", int'(out_valid), 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !fetch_stall && in_ready, "R1", "idle after reset",
              int'(fetch_stall), 0);

        // R1/R4: VL resets to 0 -> single pass-through
        stall_seen = 0;
        send(12'h0A3, 10, 20, 30, 0, "R4");
        wait_idle("R4");
        check(!stall_seen, "R4", "stall with VL=0", int'(stall_seen), 0);

        write_vl(1);
        stall_seen = 0;
        send(12'h155, 127, 127, 127, 1, "R4");
        wait_idle("R4");
        check(!stall_seen, "R4", "stall with VL=1", int'(stall_seen), 0);

        // R3/R5: VL=4, issue always ready
        write_vl(4);
        stall_seen = 0;
        send(12'h321, 1, 5, 9, 4, "R3");
        wait_idle("R3");
        check(stall_seen, "R5", "stall seen with VL=4", int'(stall_seen), 1);
        check(!fetch_stall, "R5", "stall released", int'(fetch_stall), 0);

        // R3/R6: VL=6 with intermittent issue-ready
        write_vl(6);
        ready_mode = 1;
        send(12'h7FF, 40, 0, 100, 6, "R3");
        wait_idle("R3");
        ready_mode = 0;

        // R6: issue blocked, element 0 must stay presented
        write_vl(3);
        ready_mode = 2;
        send(12'h042, 2, 3, 4, 3, "R6");
        repeat (5) @(negedge clk);
        check(out_valid && out_idx == 0 && out_rs1 == 7'd2, "R6", "blocked element held",
              int'(out_idx), 0);
        check(fetch_stall, "R5", "stall while blocked", int'(fetch_stall), 1);
        ready_mode = 0;
        wait_idle("R6");

        // R9: VL rewritten mid-sequence
        write_vl(5);
        fork
            send(12'h9A9, 11, 12, 13, 5, "R9");
            begin
                repeat (3) @(posedge clk);
                write_vl(2);
            end
        join
        wait_idle("R9");
        send(12'h9AA, 50, 51, 52, 2, "R9");
        wait_idle("R9");

        // R2: write in the same cycle as accept -> old VL used
        fork
            send(12'h0B0, 7, 8, 9, 2, "R2");
            write_vl(7);
        join
        wait_idle("R2");
        send(12'h0B1, 70, 80, 90, 7, "R2");
        wait_idle("R2");

        // R7: overflow at element 4 (rs1 124+4 = 128)
        write_vl(8);
        begin
            int err0;
            err0 = err_cnt;
            send(12'hE00, 124, 0, 0, 8, "R7");
            wait_idle("R7");
            check(err_cnt == err0 + 1, "R7", "error pulse count", err_cnt - err0, 1);
            check(in_ready && !fetch_stall, "R7", "sequence ended after error",
                  int'(fetch_stall), 0);
        end
        send(12'hE01, 100, 110, 120, 8, "R7");
        wait_idle("R7");

        // R4/R8: several single-element templates back to back
        write_vl(1);
        send(12'h001, 0, 0, 0, 1, "R4");
        send(12'h002, 1, 1, 1, 1, "R4");
        send(12'h003, 2, 2, 2, 1, "R4");
        wait_idle("R4");

        repeat (3) @(negedge clk);
        check(done_cnt == exp_done, "R8", "done pulse count", done_cnt, exp_done);
        check(err_cnt == exp_err, "R7", "error pulse total", err_cnt, exp_err);
        finished = 1;
        summary();
    end

endmodule